// File: doc/BRIEF.md
# Serial Memory Status-Write Protection Unit

This unit sits behind the serial port of a 1K x 8 serial memory. It watches the four serial lines, recognises the status-write command (one opcode byte followed by one data byte), and keeps three retained status bits. One is a pin-protect enable and two are a block-protect code. From these bits it answers, for any array address the write path offers, whether a write there may go ahead.

There are two layers of protection, and each guards a different thing. The two-bit block-protect code fences off an upper fraction of the array: a quarter, a half, or all of it. The external write-protect pin, when the enable bit is set, freezes only the status bits themselves. It never changes which array addresses are fenced.

The serial lines are oversampled by the system clock, and SPI mode 0 is used. Each SCK high phase and each SCK low phase must last at least one system clock. The serial output is never driven by this command, so its enable stays low.

Top module: `eeprom_wrstat_prot`

## Requirements
- R1: After reset the status reads 0x00, and every address from 0x000 to 0x3FF reports allow = 1.
- R2: With CS low, the opcode 0x01 followed by 8 data bits, both sent MSB first on rising SCK, is committed at the CS rise that follows exactly 16 SCK rising edges. Data bit 7 becomes the protect enable, and data bits 3:2 become the block code.
- R3: Data bits 6:4 and 1:0 are dropped, and they read back as zero in the status byte.
- R4: A status write with the write-enable-latch input low at the CS rise leaves the status unchanged.
- R5: A frame of fewer than or more than 16 SCK rising edges leaves the status unchanged.
- R6: A frame whose first byte is not 0x01 leaves the status unchanged.
- R7: While the write-protect pin is low and the protect enable is 1, a status write leaves the status unchanged.
- R8: When the write-protect pin is high, or the protect enable is 0, a status write with the latch set takes effect. This includes clearing the enable.
- R9: Block code 00 allows every address. Code 01 denies 0x300–0x3FF. Code 10 denies 0x200–0x3FF. Code 11 denies 0x000–0x3FF. The allow flag is combinational from the address.
- R10: The array allow flag depends only on the block code, and is unaffected by the pin or the enable.
- R11: The serial output enable stays low at all times.
- R12: The status never changes while CS is low, nor before the CS rise has been sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock, mode 0 |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out (held low) |
| so_oe | output | 1 | Serial output drive enable (always 0) |
| wp_n | input | 1 | Active-low write-protect pin |
| wel | input | 1 | Write-enable latch state |
| chk_addr | input | 10 | Array address to check |
| chk_allow | output | 1 | 1 when a write to chk_addr is permitted |
| status_rd | output | 8 | Status byte: bit 7 enable, bits 3:2 block code |

## Verification
The bench drives frames of 15 and 17 bits. A design that counted bits loosely would commit on these. It also drives a wrong opcode, which a design that skipped the opcode compare would accept. It probes the addresses on each side of every fence boundary (0x1FF/0x200 and 0x2FF/0x300), so a decoder that is off by one segment is caught. It exercises the enable and pin combinations, including clearing the enable while the pin is high. A design that let the pin gate array writes, or that locked the status whenever the pin was low, would diverge from the model. A per-clock comparison also flags any status change that lands before the sampled CS rise.

// File: rtl/eeprom_wrstat_pkg.sv
package eeprom_wrstat_pkg;
    localparam int BYTE_W      = 8;
    localparam int ADDR_W      = 10;
    localparam int ST_EN_BIT   = 7;
    localparam int ST_BP_LSB   = 2;
    localparam logic [BYTE_W-1:0] OP_STAT_WRITE = 8'h01;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_DATA,
        ST_FULL,
        ST_IGNORE
    } frame_state_t;
endpackage

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    output logic              cs_hi,
    output logic              bit_rise,
    output logic              byte_tick,
    output logic [BYTE_W-1:0] shreg
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic             sck_q, sck_prev, si_q;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q    <= 1'b0;
            sck_prev <= 1'b0;
            si_q     <= 1'b0;
            cs_hi    <= 1'b1;
        end else begin
            sck_q    <= sck;
            sck_prev <= sck_q;
            si_q     <= si;
            cs_hi    <= cs_n;
        end
    end

    assign bit_rise = sck_q && !sck_prev && !cs_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            shreg     <= '0;
            byte_tick <= 1'b0;
        end else begin
            byte_tick <= bit_rise && (cnt == CNT_W'(BYTE_W - 1));
            if (cs_hi) begin
                cnt <= '0;
            end else if (bit_rise) begin
                cnt   <= cnt + 1'b1;
                shreg <= {shreg[BYTE_W-2:0], si_q};
            end
        end
    end
endmodule

// File: rtl/wrstat_frame_fsm.sv
module wrstat_frame_fsm
    import eeprom_wrstat_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_hi,
    input  logic              bit_rise,
    input  logic              byte_tick,
    input  logic [BYTE_W-1:0] shreg,
    output logic              commit
);
    frame_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (cs_hi) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   state_nx = ST_OPCODE;
                ST_OPCODE: if (byte_tick)
                               state_nx = (shreg == OP_STAT_WRITE) ? ST_DATA : ST_IGNORE;
                ST_DATA:   if (byte_tick) state_nx = ST_FULL;
                ST_FULL:   if (bit_rise)  state_nx = ST_IGNORE;
                ST_IGNORE: state_nx = ST_IGNORE;
                default:   state_nx = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        commit = (state == ST_FULL) && cs_hi;
    end
endmodule

// File: rtl/status_store.sv
module status_store #(
    parameter int BYTE_W = 8,
    parameter int EN_BIT = 7,
    parameter int BP_LSB = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              wp_n,
    input  logic              wel,
    output logic              prot_en,
    output logic [1:0]        bp
);
    logic hw_lock;
    assign hw_lock = !wp_n && prot_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prot_en <= 1'b0;
            bp      <= 2'b00;
        end else if (commit && wel && !hw_lock) begin
            prot_en <= wr_byte[EN_BIT];
            bp      <= wr_byte[BP_LSB+1:BP_LSB];
        end
    end
endmodule

// File: rtl/block_fence.sv
module block_fence #(
    parameter int ADDR_W = 10
) (
    input  logic [1:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              allow
);
    always_comb begin
        unique case (bp)
            2'b00: allow = 1'b1;
            2'b01: allow = !(&addr[ADDR_W-1:ADDR_W-2]);
            2'b10: allow = !addr[ADDR_W-1];
            2'b11: allow = 1'b0;
            default: allow = 1'b0;
        endcase
    end
endmodule

// File: rtl/eeprom_wrstat_prot.sv
module eeprom_wrstat_prot
    import eeprom_wrstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    output logic              so,
    output logic              so_oe,
    input  logic              wp_n,
    input  logic              wel,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic              chk_allow,
    output logic [BYTE_W-1:0] status_rd
);
    logic              cs_hi, bit_rise, byte_tick, commit, prot_en;
    logic [BYTE_W-1:0] shreg;
    logic [1:0]        bp;

    spi_bit_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .cs_hi(cs_hi), .bit_rise(bit_rise), .byte_tick(byte_tick), .shreg(shreg)
    );

    wrstat_frame_fsm #(.BYTE_W(BYTE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi), .bit_rise(bit_rise),
        .byte_tick(byte_tick), .shreg(shreg), .commit(commit)
    );

    status_store #(.BYTE_W(BYTE_W), .EN_BIT(ST_EN_BIT), .BP_LSB(ST_BP_LSB)) u_stat (
        .clk(clk), .rst_n(rst_n), .commit(commit), .wr_byte(shreg),
        .wp_n(wp_n), .wel(wel), .prot_en(prot_en), .bp(bp)
    );

    block_fence #(.ADDR_W(ADDR_W)) u_fence (
        .bp(bp), .addr(chk_addr), .allow(chk_allow)
    );

    always_comb begin
        status_rd                        = '0;
        status_rd[ST_EN_BIT]             = prot_en;
        status_rd[ST_BP_LSB+1:ST_BP_LSB] = bp;
        so                               = 1'b0;
        so_oe                            = 1'b0;
    end
endmodule

// File: rtl/wrstat_prot_checker.sv
module wrstat_prot_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       wp_n,
    input logic       wel,
    input logic [9:0] chk_addr,
    input logic       chk_allow,
    input logic [7:0] status_rd
);
    a_r4_change_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status_rd) |-> $past(wel));

    a_r7_pin_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status_rd) |-> !(!$past(wp_n) && $past(status_rd[7])));

    a_r12_change_after_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status_rd) |-> $past(cs_n));

    a_r9_all_fenced: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd[3:2] == 2'b11) |-> !chk_allow);

    a_r9_none_fenced: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd[3:2] == 2'b00) |-> chk_allow);

    a_r10_lower_open_at_quarter: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd[3:2] == 2'b01 && chk_addr[9:8] != 2'b11) |-> chk_allow);
endmodule

bind eeprom_wrstat_prot wrstat_prot_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .wel(wel),
    .chk_addr(chk_addr), .chk_allow(chk_allow), .status_rd(status_rd)
);

// File: tb/eeprom_wrstat_prot_bench.sv
module eeprom_wrstat_prot_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, cs_n = 1'b1, si = 1'b0;
    logic       wp_n = 1'b1, wel = 1'b1;
    logic [9:0] chk_addr = '0;
    logic       so, so_oe, chk_allow;
    logic [7:0] status_rd;

    int n_checks = 0, n_fail = 0, cycles = 0;
    bit mon_en = 1'b0;
    logic [7:0] exp_stat = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_wrstat_prot u_eeprom_wrstat_prot (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .so(so), .so_oe(so_oe), .wp_n(wp_n), .wel(wel),
        .chk_addr(chk_addr), .chk_allow(chk_allow), .status_rd(status_rd)
    );

    function automatic bit model_allow(logic [7:0] st, int addr);
        int lim;
        case (st[3:2])
            2'b00: lim = 1024;
            2'b01: lim = 768;
            2'b10: lim = 512;
            default: lim = 0;
        endcase
        return addr < lim;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    // per-clock comparison against the behavioural model
    always @(negedge clk) begin
        if (rst_n) begin
            check(so_oe == 1'b0, "R11", so_oe, 0);
            if (mon_en) begin
                check(status_rd == exp_stat, "R12", status_rd, exp_stat);
                check(chk_allow == model_allow(exp_stat, chk_addr), "R9", chk_allow,
                      model_allow(exp_stat, chk_addr));
            end
        end
    end

    // sends nbits taken MSB-first from {op, data}, padding with zeros
    task automatic frame(logic [7:0] op, logic [7:0] data, int nbits);
        logic [15:0] word = {op, data};
        bit ok;
        ok = (op == 8'h01) && (nbits == 16) && wel && !(!wp_n && exp_stat[7]);
        step(1);
        cs_n = 1'b0;
        step(2);
        for (int i = 0; i < nbits; i++) begin
            si  = (i < 16) ? word[15-i] : 1'b0;
            sck = 1'b0; step(2);
            sck = 1'b1; step(2);
        end
        sck = 1'b0;
        step(2);
        mon_en = 1'b0;
        cs_n = 1'b1;
        step(3);
        if (ok) exp_stat = {data[7], 3'b000, data[3:2], 2'b00};
        mon_en = 1'b1;
        step(1);
    endtask

    task automatic probe(int addr, string req);
        chk_addr = addr[9:0];
        @(negedge clk);
        check(chk_allow == model_allow(exp_stat, addr), req, chk_allow,
              model_allow(exp_stat, addr));
    endtask

    task automatic stat_is(string req);
        @(negedge clk);
        check(status_rd == exp_stat, req, status_rd, exp_stat);
    endtask

    initial begin : watchdog
        while (cycles < WATCHDOG) begin @(posedge clk); cycles++; end
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, WATCHDOG);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        mon_en = 1'b1;
        step(1);
        stat_is("R1");
        probe(10'h3FF, "R1");
        probe(10'h000, "R1");

        frame(8'h01, 8'hF3, 16);            // R2 R3: enable set, code 00, junk bits dropped
        stat_is("R3");
        check(status_rd == 8'h80, "R2", status_rd, 8'h80);

        frame(8'h01, 8'h04, 16);            // R8: pin high, enable set -> writable
        stat_is("R8");
        probe(10'h2FF, "R9");
        probe(10'h300, "R9");

        wel = 1'b0;
        frame(8'h01, 8'h08, 16);            // R4
        stat_is("R4");
        wel = 1'b1;

        frame(8'h02, 8'h08, 16);            // R6
        stat_is("R6");
        frame(8'h01, 8'h08, 15);            // R5 short
        stat_is("R5");
        frame(8'h01, 8'h08, 17);            // R5 long
        stat_is("R5");

        frame(8'h01, 8'h08, 16);            // code 10
        stat_is("R2");
        probe(10'h1FF, "R9");
        probe(10'h200, "R9");

        frame(8'h01, 8'h84, 16);            // enable + code 01
        stat_is("R2");
        wp_n = 1'b0;
        frame(8'h01, 8'h00, 16);            // R7: locked
        stat_is("R7");
        check(status_rd == 8'h84, "R7", status_rd, 8'h84);
        probe(10'h3FF, "R10");
        probe(10'h000, "R10");
        probe(10'h2FF, "R10");

        wp_n = 1'b1;
        frame(8'h01, 8'h0C, 16);            // R8: pin high, enable cleared, code 11
        stat_is("R8");
        probe(10'h000, "R9");
        wp_n = 1'b0;
        frame(8'h01, 8'h00, 16);            // R8: enable low -> writable though pin low
        stat_is("R8");
        check(status_rd == 8'h00, "R8", status_rd, 8'h00);
        probe(10'h3FF, "R10");

        step(4);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule